// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns a fast system clock into the bit-level timing a CAN node needs. A prescaler makes a time quantum from the system clock. Each bit is then built from quanta in three parts: one synchronization quantum, a programmable first phase and a programmable second phase. The receive line is sampled where the first phase ends. The block gives that sampled level, a one-clock sample strobe and a one-clock bit-start strobe to the frame logic that sits around it.

The start of a bit is not fixed to the local clock. The first falling (recessive-to-dominant) edge seen in a bit moves the timing. A late edge makes the first phase longer, and an early edge makes the second phase shorter. The move is never larger than a programmed jump width. The timing fields are captured only while the controller is held in its initialize state. While that state is active, the timing machinery stays parked at the start of a bit.

Top module: `cbt_bit_timing`

## Requirements
- R1: While `rst` is high, or while `cfg_init` is high, `sample_pulse` and `bit_start` stay 0 and `rx_bit` reads 1 (recessive). When `cfg_init` falls, a new bit begins with its synchronization quantum.
- R2: One time quantum lasts 2 × (`cfg_brp` + 1) system clocks. The first clock edge with `cfg_init` low counts as edge 1. Quantum k (counting from 0) ends on edge P·(k+1), where P is the quantum length.
- R3: A bit with no resynchronization lasts 1 + (`cfg_seg1` + 1) + (`cfg_seg2` + 1) quanta. `bit_start` is high for the one clock after the edge that ends the second phase. It is never high in the clock right after a sample strobe.
- R4: `sample_pulse` is high for exactly one clock, after the edge that ends the last quantum of the first phase. On that same edge `rx_bit` takes the level that `rx_in` had one clock before the edge.
- R5: The timing fields are captured from the `cfg_*` inputs on a clock where both `cfg_we` and `cfg_init` are high. A write while `cfg_init` is low has no effect on the timing.
- R6: A falling edge that lands in quantum j of the first phase (j = 1 for its first quantum) makes that phase longer by min(j, `cfg_sjw` + 1) quanta. An edge counts as landing in a quantum when `rx_in` was low one clock before the edge that ends that quantum and was high one clock before the edge that ended the previous quantum.
- R7: A falling edge that lands in the second phase, with r of its quanta still to follow, makes that phase shorter by min(r, `cfg_sjw` + 1) quanta. An edge in its last quantum (r = 0) therefore has no effect.
- R8: A falling edge that lands in the synchronization quantum does not move the timing.
- R9: Rising (dominant-to-recessive) edges never move the timing.
- R10: Only the first falling edge in a bit may move the timing. Later edges in the same bit are ignored.
- R11: `sample_pulse` and `bit_start` are never high together. `rx_bit` changes only on a sample strobe or on entry to the initialize state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_init | input | 1 | Initialize state: holds the timing and unlocks configuration writes |
| cfg_we | input | 1 | Write strobe for the timing fields |
| cfg_brp | input | BRP_W | Prescaler code; a quantum lasts 2·(code+1) clocks |
| cfg_seg1 | input | SEG1_W | First-phase length code, code+1 quanta |
| cfg_seg2 | input | SEG2_W | Second-phase length code, code+1 quanta |
| cfg_sjw | input | SJW_W | Jump-width code, code+1 quanta |
| rx_in | input | 1 | Raw receive line, 1 = recessive |
| sample_pulse | output | 1 | One-clock strobe at the sampling point |
| bit_start | output | 1 | One-clock strobe when a new bit begins |
| rx_bit | output | 1 | Bus level captured at the last sampling point |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler, 4-bit first phase, 3-bit second phase and 2-bit jump width. Most scenarios use a 4-clock quantum, so each shift of one quantum shows as a 4-cycle move of a strobe. This lets the scenarios place an edge in any chosen quantum and tell clamped shifts from unclamped ones. The same build also reaches the extremes of each field: the shortest quantum (prescaler code 0), the longest (code 63), and the longest bit (16 + 8 quanta in the two phases).

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int DEF_BRP_W  = 6;
    localparam int DEF_SEG1_W = 4;
    localparam int DEF_SEG2_W = 3;
    localparam int DEF_SJW_W  = 2;

    // Position of the bit sequencer inside one bit
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    // Strobes and captured level leaving the sequencer
    typedef struct packed {
        logic smp;
        logic bst;
        logic lvl;
    } strobe_t;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
    parameter int BRP_W  = 6,
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              we,
    input  logic [BRP_W-1:0]  brp_d,
    input  logic [SEG1_W-1:0] seg1_d,
    input  logic [SEG2_W-1:0] seg2_d,
    input  logic [SJW_W-1:0]  sjw_d,
    output logic [BRP_W-1:0]  brp_q,
    output logic [SEG1_W-1:0] seg1_q,
    output logic [SEG2_W-1:0] seg2_q,
    output logic [SJW_W-1:0]  sjw_q
);

    logic wr_ok;
    assign wr_ok = we & init;

    always_ff @(posedge clk) begin
        if (rst) begin
            brp_q  <= '0;
            seg1_q <= '0;
            seg2_q <= '0;
            sjw_q  <= '0;
        end else if (wr_ok) begin
            brp_q  <= brp_d;
            seg1_q <= seg1_d;
            seg2_q <= seg2_d;
            sjw_q  <= sjw_d;
        end
    end

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [BRP_W-1:0] brp,
    output logic             tick
);

    localparam int CW = BRP_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // A quantum is 2*(brp+1) clocks, so the terminal count is 2*brp+1
    assign last = {brp, 1'b1};
    assign tick = ~hold & (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic tick,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);

    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s <= 1'b1;
        end else begin
            rx_s <= rx_in;
        end
    end

    // Reference level is taken once per quantum; while held it follows the line
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b1;
        end else if (hold || tick) begin
            lvl_q <= rx_s;
        end
    end

    assign fall = tick & lvl_q & ~rx_s;

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import cbt_pkg::*;
#(
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              tick,
    input  logic              fall,
    input  logic              rx_s,
    input  logic [SEG1_W-1:0] seg1_code,
    input  logic [SEG2_W-1:0] seg2_code,
    input  logic [SJW_W-1:0]  sjw_code,
    output strobe_t           strb
);

    localparam int WMAX = (SEG1_W > SJW_W) ? SEG1_W : SJW_W;
    localparam int CW   = WMAX + 2;

    seg_e          seg_q;
    logic [CW-1:0] qcnt_q;
    logic [CW-1:0] ext_q;
    logic [CW-1:0] cut_q;
    logic          done_q;
    strobe_t       strb_q;

    logic [CW-1:0] seg1_len, seg2_len, sjw_len;
    logic [CW-1:0] late_err, early_rem;
    logic [CW-1:0] ext_new, cut_new, ext_eff, cut_eff;
    logic          take, ph1_end, ph2_end;

    always_comb begin
        seg1_len  = CW'(seg1_code) + CW'(1);
        seg2_len  = CW'(seg2_code) + CW'(1);
        sjw_len   = CW'(sjw_code) + CW'(1);
        take      = fall & ~done_q;
        late_err  = qcnt_q + CW'(1);
        early_rem = seg2_len - CW'(1) - qcnt_q;
        ext_new   = CW'(umin(int'(late_err), int'(sjw_len)));
        cut_new   = CW'(umin(int'(early_rem), int'(sjw_len)));
        ext_eff   = (seg_q == SEG_PH1 && take) ? ext_new : ext_q;
        cut_eff   = (seg_q == SEG_PH2 && take) ? cut_new : cut_q;
        ph1_end   = (qcnt_q == seg1_len + ext_eff - CW'(1));
        ph2_end   = (qcnt_q == seg2_len - CW'(1) - cut_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            seg_q  <= SEG_SYNC;
            qcnt_q <= '0;
            ext_q  <= '0;
            cut_q  <= '0;
            done_q <= 1'b0;
            strb_q <= '{smp: 1'b0, bst: 1'b0, lvl: 1'b1};
        end else begin
            strb_q.smp <= 1'b0;
            strb_q.bst <= 1'b0;
            if (tick) begin
                unique case (seg_q)
                    SEG_SYNC: begin
                        seg_q  <= SEG_PH1;
                        qcnt_q <= '0;
                        if (fall) done_q <= 1'b1;
                    end
                    SEG_PH1: begin
                        if (take) begin
                            done_q <= 1'b1;
                            ext_q  <= ext_new;
                        end
                        if (ph1_end) begin
                            seg_q      <= SEG_PH2;
                            qcnt_q     <= '0;
                            strb_q.smp <= 1'b1;
                            strb_q.lvl <= rx_s;
                        end else begin
                            qcnt_q <= qcnt_q + CW'(1);
                        end
                    end
                    SEG_PH2: begin
                        if (take) begin
                            done_q <= 1'b1;
                            cut_q  <= cut_new;
                        end
                        if (ph2_end) begin
                            seg_q      <= SEG_SYNC;
                            qcnt_q     <= '0;
                            ext_q      <= '0;
                            cut_q      <= '0;
                            done_q     <= 1'b0;
                            strb_q.bst <= 1'b1;
                        end else begin
                            qcnt_q <= qcnt_q + CW'(1);
                        end
                    end
                    default: begin
                        seg_q  <= SEG_SYNC;
                        qcnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign strb = strb_q;

endmodule

// File: rtl/cbt_bit_timing.sv
module cbt_bit_timing
    import cbt_pkg::*;
#(
    parameter int BRP_W  = DEF_BRP_W,
    parameter int SEG1_W = DEF_SEG1_W,
    parameter int SEG2_W = DEF_SEG2_W,
    parameter int SJW_W  = DEF_SJW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_init,
    input  logic              cfg_we,
    input  logic [BRP_W-1:0]  cfg_brp,
    input  logic [SEG1_W-1:0] cfg_seg1,
    input  logic [SEG2_W-1:0] cfg_seg2,
    input  logic [SJW_W-1:0]  cfg_sjw,
    input  logic              rx_in,
    output logic              sample_pulse,
    output logic              bit_start,
    output logic              rx_bit
);

    logic [BRP_W-1:0]  brp_q;
    logic [SEG1_W-1:0] seg1_q;
    logic [SEG2_W-1:0] seg2_q;
    logic [SJW_W-1:0]  sjw_q;
    logic              tq_tick;
    logic              rx_s;
    logic              rx_fall;
    strobe_t           strb;

    cbt_cfg_regs #(
        .BRP_W (BRP_W),
        .SEG1_W(SEG1_W),
        .SEG2_W(SEG2_W),
        .SJW_W (SJW_W)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .init  (cfg_init),
        .we    (cfg_we),
        .brp_d (cfg_brp),
        .seg1_d(cfg_seg1),
        .seg2_d(cfg_seg2),
        .sjw_d (cfg_sjw),
        .brp_q (brp_q),
        .seg1_q(seg1_q),
        .seg2_q(seg2_q),
        .sjw_q (sjw_q)
    );

    cbt_prescaler #(.BRP_W(BRP_W)) u_psc (
        .clk (clk),
        .rst (rst),
        .hold(cfg_init),
        .brp (brp_q),
        .tick(tq_tick)
    );

    cbt_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .hold (cfg_init),
        .tick (tq_tick),
        .rx_in(rx_in),
        .rx_s (rx_s),
        .fall (rx_fall)
    );

    cbt_seg_fsm #(
        .SEG1_W(SEG1_W),
        .SEG2_W(SEG2_W),
        .SJW_W (SJW_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .hold     (cfg_init),
        .tick     (tq_tick),
        .fall     (rx_fall),
        .rx_s     (rx_s),
        .seg1_code(seg1_q),
        .seg2_code(seg2_q),
        .sjw_code (sjw_q),
        .strb     (strb)
    );

    assign sample_pulse = strb.smp;
    assign bit_start    = strb.bst;
    assign rx_bit       = strb.lvl;

endmodule

// File: rtl/cbt_bit_timing_chk.sv
module cbt_bit_timing_chk #(
    parameter int BRP_W  = 6,
    parameter int SEG1_W = 4,
    parameter int SEG2_W = 3,
    parameter int SJW_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_init,
    input logic              sample_pulse,
    input logic              bit_start,
    input logic              rx_bit,
    input logic [BRP_W-1:0]  brp_q,
    input logic [SEG1_W-1:0] seg1_q,
    input logic [SEG2_W-1:0] seg2_q,
    input logic [SJW_W-1:0]  sjw_q
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_init |=> (!sample_pulse && !bit_start && rx_bit));

    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_init |=> $stable({brp_q, seg1_q, seg2_q, sjw_q}));

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(sample_pulse && bit_start));

    p_bit_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(rx_bit) && !$past(cfg_init)) |-> sample_pulse);

    p_smp_single_r4: assert property (@(posedge clk) disable iff (rst)
        sample_pulse |=> !sample_pulse);

    p_bst_gap_r3: assert property (@(posedge clk) disable iff (rst)
        sample_pulse |=> !bit_start);

    p_bst_single_r3: assert property (@(posedge clk) disable iff (rst)
        bit_start |=> !bit_start);

endmodule

bind cbt_bit_timing cbt_bit_timing_chk #(
    .BRP_W (BRP_W),
    .SEG1_W(SEG1_W),
    .SEG2_W(SEG2_W),
    .SJW_W (SJW_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_init    (cfg_init),
    .sample_pulse(sample_pulse),
    .bit_start   (bit_start),
    .rx_bit      (rx_bit),
    .brp_q       (brp_q),
    .seg1_q      (seg1_q),
    .seg2_q      (seg2_q),
    .sjw_q       (sjw_q)
);

// File: tb/cbt_bit_timing_tb.sv
module cbt_bit_timing_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_init = 1'b1;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_brp = '0;
    logic [3:0] cfg_seg1 = '0;
    logic [2:0] cfg_seg2 = '0;
    logic [1:0] cfg_sjw = '0;
    logic       rx_in = 1'b1;
    logic       sample_pulse, bit_start, rx_bit;

    int n_chk = 0;
    int n_fail = 0;
    int got_smp, got_bst, got_smp2;
    logic got_bit;

    always #2 clk = ~clk;

    cbt_bit_timing u_dut (
        .clk(clk), .rst(rst), .cfg_init(cfg_init), .cfg_we(cfg_we),
        .cfg_brp(cfg_brp), .cfg_seg1(cfg_seg1), .cfg_seg2(cfg_seg2),
        .cfg_sjw(cfg_sjw), .rx_in(rx_in), .sample_pulse(sample_pulse),
        .bit_start(bit_start), .rx_bit(rx_bit)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Per-cycle stimulus: up to three rx changes and one illegal write
    task automatic stim(input int cyc, input int c0, input logic v0,
                        input int c1, input logic v1, input int c2, input logic v2,
                        input int wcyc);
        if (cyc == c0) rx_in = v0;
        if (cyc == c1) rx_in = v1;
        if (cyc == c2) rx_in = v2;
        if (cyc == wcyc) begin
            cfg_we = 1'b1; cfg_brp = 6'd0; cfg_seg1 = 4'd0;
            cfg_seg2 = 3'd0; cfg_sjw = 2'd3;
        end
        if (cyc == wcyc + 1) cfg_we = 1'b0;
    endtask

    task automatic run_bit(input int brp, input int s1, input int s2, input int sjw,
                           input logic rx0, input int c0, input logic v0,
                           input int c1, input logic v1, input int c2, input logic v2,
                           input int wcyc);
        int cyc;
        @(negedge clk);
        cfg_init = 1'b1; rx_in = rx0; cfg_we = 1'b1;
        cfg_brp = 6'(brp); cfg_seg1 = 4'(s1); cfg_seg2 = 3'(s2); cfg_sjw = 2'(sjw);
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        cfg_init = 1'b0;
        cyc = 0;
        got_smp = -1; got_bst = -1; got_smp2 = -1; got_bit = 1'bx;
        stim(cyc, c0, v0, c1, v1, c2, v2, wcyc);
        while (got_smp2 < 0 && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (sample_pulse) begin
                if (got_smp < 0) begin
                    got_smp = cyc; got_bit = rx_bit;
                end else if (got_bst >= 0) begin
                    got_smp2 = cyc;
                end
            end
            if (bit_start && got_bst < 0) got_bst = cyc;
            stim(cyc, c0, v0, c1, v1, c2, v2, wcyc);
        end
        cfg_we = 1'b0;
        cfg_init = 1'b1;
        rx_in = 1'b1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 smp in reset", int'(sample_pulse), 0);
        check("R1 bst in reset", int'(bit_start), 0);
        check("R1 rx_bit in reset", int'(rx_bit), 1);
        rst = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sample_pulse || bit_start) check("R1 strobe while init", 1, 0);
        end
        check("R1 quiet under init", int'(sample_pulse | bit_start), 0);
    endtask

    // P=4, S1=5, S2=4, SJW=2, bit=10 quanta
    task automatic t_nominal();
        run_bit(1, 4, 3, 1, 1'b1, -1, 1'b1, -1, 1'b1, -1, 1'b1, -10);
        check("R2 R4 first sample", got_smp, 24);
        check("R3 bit start", got_bst, 40);
        check("R3 second sample", got_smp2, 64);
        check("R4 sampled recessive", int'(got_bit), 1);
    endtask

    task automatic t_sync_edge();
        run_bit(1, 4, 3, 1, 1'b1, 0, 1'b0, -1, 1'b1, -1, 1'b1, -10);
        check("R8 sample unshifted", got_smp, 24);
        check("R8 start unshifted", got_bst, 40);
        check("R4 sampled dominant", int'(got_bit), 0);
    endtask

    task automatic t_late_small();
        run_bit(1, 4, 3, 1, 1'b1, 4, 1'b0, -1, 1'b1, -1, 1'b1, -10);
        check("R6 late j=1 sample", got_smp, 28);
        check("R6 late j=1 start", got_bst, 44);
    endtask

    task automatic t_late_clamp();
        run_bit(1, 4, 3, 1, 1'b1, 16, 1'b0, -1, 1'b1, -1, 1'b1, -10);
        check("R6 late j=4 clamped sample", got_smp, 32);
        check("R6 late j=4 clamped start", got_bst, 48);
    endtask

    task automatic t_early();
        run_bit(1, 4, 3, 1, 1'b1, 24, 1'b0, -1, 1'b1, -1, 1'b1, -10);
        check("R7 early r=3 clamped", got_bst, 32);
        check("R4 sample before edge", int'(got_bit), 1);
        run_bit(1, 4, 3, 1, 1'b1, 32, 1'b0, -1, 1'b1, -1, 1'b1, -10);
        check("R7 early r=1", got_bst, 36);
        run_bit(1, 4, 3, 1, 1'b1, 36, 1'b0, -1, 1'b1, -1, 1'b1, -10);
        check("R7 early r=0 no shift", got_bst, 40);
    endtask

    task automatic t_one_resync();
        run_bit(1, 4, 3, 1, 1'b1, 4, 1'b0, 8, 1'b1, 12, 1'b0, -10);
        check("R10 second edge ignored sample", got_smp, 28);
        check("R10 second edge ignored start", got_bst, 44);
    endtask

    task automatic t_rising();
        run_bit(1, 4, 3, 1, 1'b0, 4, 1'b1, -1, 1'b1, -1, 1'b1, -10);
        check("R9 rising edge sample", got_smp, 24);
        check("R9 rising edge start", got_bst, 40);
    endtask

    task automatic t_prescale();
        run_bit(0, 4, 3, 1, 1'b1, -1, 1'b1, -1, 1'b1, -1, 1'b1, -10);
        check("R2 brp=0 sample", got_smp, 12);
        check("R2 brp=0 start", got_bst, 20);
        run_bit(63, 4, 3, 1, 1'b1, -1, 1'b1, -1, 1'b1, -1, 1'b1, -10);
        check("R2 brp=63 sample", got_smp, 768);
        check("R2 brp=63 start", got_bst, 1280);
    endtask

    task automatic t_max_segs();
        run_bit(1, 15, 7, 1, 1'b1, -1, 1'b1, -1, 1'b1, -1, 1'b1, -10);
        check("R3 longest phases sample", got_smp, 68);
        check("R3 longest phases start", got_bst, 100);
    endtask

    task automatic t_locked_write();
        run_bit(1, 4, 3, 1, 1'b1, -1, 1'b1, -1, 1'b1, -1, 1'b1, 2);
        check("R5 write ignored sample", got_smp, 24);
        check("R5 write ignored start", got_bst, 40);
        check("R5 write ignored next bit", got_smp2, 64);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_nominal();
        t_sync_edge();
        t_late_small();
        t_late_clamp();
        t_early();
        t_one_resync();
        t_rising();
        t_prescale();
        t_max_segs();
        t_locked_write();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule